// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a request to write to an I/O port may go ahead. Each request carries the privilege context (protection enable, virtual-8086 flag, current privilege level, I/O privilege level), a port address, an access size code and a lock-prefix flag. The answer is a one-cycle pulse. A grant pulse forwards the port address and size toward the I/O bus. A fault pulse carries a code that names the kind of fault.

When the context lacks I/O privilege, the block reads a permission bitmap that holds one bit per port. A multi-byte access can straddle two bitmap words, so this path takes one or two synchronous reads. Software fills the bitmap through a word-wide write port. The block takes one request at a time: `reqReady` is low while a bitmap lookup is in flight.

Top module: `io_port_gate`

## Requirements
- R1: A request with `lockPrefix`=1 ends in `faultValid` with `faultKind`=2 (invalid opcode), one cycle after acceptance, whatever the privilege context.
- R2: Size code 3 is not a legal size. It ends in `faultValid` with `faultKind`=2, one cycle after acceptance.
- R3: The bitmap is not consulted when `protEn`=0 (whatever `v86Mode` and the levels are), or when `protEn`=1, `v86Mode`=0 and `cpl`<=`iopl`. Such a request gets `grantValid` one cycle after acceptance, with `ioAddr` equal to the port and `ioSize` equal to the size code.
- R4: When `protEn`=1 and either `cpl`>`iopl` or `v86Mode`=1, the bitmap is consulted. Port p maps to bit (p mod WORD_W) of word (p / WORD_W). A set bit ends the request in `faultValid` with `faultKind`=1 (general protection, error code 0). If no covered bit is set, the request is granted.
- R5: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. An access of n bytes at port p covers ports p through p+n-1, even when they fall in two bitmap words.
- R6: A checked request answers two cycles after acceptance when its ports lie in one word, and three cycles after when they span two words. `reqReady` is low until the answer appears.
- R7: A checked access that would run past the highest port is refused with `faultKind`=1.
- R8: `grantValid` and `faultValid` are never high together. Each request yields exactly one single-cycle pulse.
- R9: A word written through `bmWrEn`/`bmWrAddr`/`bmWrData` governs every check accepted afterwards.
- R10: During and right after reset, both result pulses are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; accepted when `reqReady` is high |
| protEn | input | 1 | Protection enabled |
| v86Mode | input | 1 | Virtual-8086 mode active |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| portAddr | input | PORT_W | Port address |
| accSize | input | 2 | 0 = byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| lockPrefix | input | 1 | Lock prefix present |
| bmWrEn | input | 1 | Bitmap word write enable |
| bmWrAddr | input | PORT_W-log2(WORD_W) | Bitmap word index |
| bmWrData | input | WORD_W | Bitmap word data |
| reqReady | output | 1 | Idle, can accept a request |
| grantValid | output | 1 | One-cycle grant pulse |
| faultValid | output | 1 | One-cycle fault pulse |
| faultKind | output | 2 | 1 = general protection, 2 = invalid opcode |
| ioAddr | output | PORT_W | Granted port address |
| ioSize | output | 2 | Granted size code |

## Verification
The bench builds the block with PORT_W=10 and WORD_W=8, which gives 1024 ports in 128 words. Because the words are narrow, 2-byte and 4-byte accesses cross a word boundary at many offsets. This makes the two-read path and the early refusal of an access at the top port easy to reach. The same parameters let the bench clear the whole bitmap and then plant blocked bits at chosen ports, next to word edges.

// File: rtl/io_gate_pkg.sv
package io_gate_pkg;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_UD   = 2'd2
  } faultKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic rdFirst;
    logic rdSecond;
    logic grant;
    logic fault;
    logic faultUd;
  } gateStrobeT;

  // conditions from datapath to control
  typedef struct packed {
    logic inUd;
    logic inCheck;
    logic firstHit;
    logic spans;
    logic lastWord;
    logic secondHit;
  } gateStatusT;

endpackage

// File: rtl/io_gate_dp.sv
module io_gate_dp
  import io_gate_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  gateStrobeT                    strobe,
  output gateStatusT                    status,
  input  logic                          protEn,
  input  logic                          v86Mode,
  input  logic [1:0]                    cpl,
  input  logic [1:0]                    iopl,
  input  logic [PORT_W-1:0]             portAddr,
  input  logic [1:0]                    accSize,
  input  logic                          lockPrefix,
  input  logic                          bmWrEn,
  input  logic [PORT_W-$clog2(WORD_W)-1:0] bmWrAddr,
  input  logic [WORD_W-1:0]             bmWrData,
  output logic                          grantValid,
  output logic                          faultValid,
  output logic [1:0]                    faultKind,
  output logic [PORT_W-1:0]             ioAddr,
  output logic [1:0]                    ioSize
);
  localparam int OFF_W = $clog2(WORD_W);
  localparam int IDX_W = PORT_W - OFF_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0]   bitmap [DEPTH];
  logic [WORD_W-1:0]   rdWord;
  logic [PORT_W-1:0]   portQ;
  logic [1:0]          sizeQ;
  logic [IDX_W-1:0]    idxQ;
  logic [OFF_W-1:0]    offQ;
  logic [IDX_W-1:0]    rdIdx;
  logic [3:0]          fillBits;
  logic [2*WORD_W-1:0] spanMask;
  logic [WORD_W-1:0]   lowMask;
  logic [WORD_W-1:0]   highMask;

  assign idxQ = portQ[PORT_W-1:OFF_W];
  assign offQ = portQ[OFF_W-1:0];

  // bitmap storage
  always_ff @(posedge clk) begin
    if (bmWrEn) bitmap[bmWrAddr] <= bmWrData;
  end

  assign rdIdx = strobe.rdSecond ? idxQ + IDX_W'(1) : portAddr[PORT_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (strobe.rdFirst || strobe.rdSecond) rdWord <= bitmap[rdIdx];
  end

  // request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ <= '0;
      sizeQ <= '0;
    end else if (strobe.accept) begin
      portQ <= portAddr;
      sizeQ <= accSize;
    end
  end

  always_comb begin
    case (sizeQ)
      2'd0:    fillBits = 4'b0001;
      2'd1:    fillBits = 4'b0011;
      default: fillBits = 4'b1111;
    endcase
  end

  assign spanMask = {{(2*WORD_W-4){1'b0}}, fillBits} << offQ;
  assign lowMask  = spanMask[WORD_W-1:0];
  assign highMask = spanMask[2*WORD_W-1:WORD_W];

  assign status.inUd      = lockPrefix || (accSize == 2'd3);
  assign status.inCheck   = protEn && ((cpl > iopl) || v86Mode);
  assign status.firstHit  = |(rdWord & lowMask);
  assign status.spans     = |highMask;
  assign status.lastWord  = &idxQ;
  assign status.secondHit = |(rdWord & highMask);

  // registered result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      faultValid <= 1'b0;
      faultKind  <= FK_NONE;
      ioAddr     <= '0;
      ioSize     <= '0;
    end else begin
      grantValid <= strobe.grant;
      faultValid <= strobe.fault;
      if (strobe.fault) faultKind <= strobe.faultUd ? FK_UD : FK_GP;
      if (strobe.grant) begin
        ioAddr <= strobe.accept ? portAddr : portQ;
        ioSize <= strobe.accept ? accSize : sizeQ;
      end
    end
  end

  // R8: one result kind per cycle
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantValid, faultValid}));

  // R4: a fault always carries a defined kind
  a_r4_kind_defined: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultKind == FK_GP || faultKind == FK_UD));

endmodule

// File: rtl/io_gate_ctl.sv
module io_gate_ctl
  import io_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  gateStatusT status,
  output gateStrobeT strobe,
  output logic       reqReady
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT1, S_WAIT2} ctlStateT;
  ctlStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.accept = 1'b1;
        if (status.inUd) begin
          strobe.fault   = 1'b1;
          strobe.faultUd = 1'b1;
        end else if (!status.inCheck) begin
          strobe.grant = 1'b1;
        end else begin
          strobe.rdFirst = 1'b1;
          nextState      = S_WAIT1;
        end
      end
      S_WAIT1: begin
        nextState = S_IDLE;
        if (status.firstHit) strobe.fault = 1'b1;
        else if (status.spans) begin
          if (status.lastWord) strobe.fault = 1'b1;
          else begin
            strobe.rdSecond = 1'b1;
            nextState       = S_WAIT2;
          end
        end else strobe.grant = 1'b1;
      end
      S_WAIT2: begin
        nextState = S_IDLE;
        if (status.secondHit) strobe.fault = 1'b1;
        else                  strobe.grant = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);

  // R6: the second read always follows the first by one cycle
  a_r6_second_follows_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdSecond |-> $past(strobe.rdFirst));

endmodule

// File: rtl/io_port_gate.sv
module io_port_gate
  import io_gate_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int WORD_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  input  logic                             protEn,
  input  logic                             v86Mode,
  input  logic [1:0]                       cpl,
  input  logic [1:0]                       iopl,
  input  logic [PORT_W-1:0]                portAddr,
  input  logic [1:0]                       accSize,
  input  logic                             lockPrefix,
  input  logic                             bmWrEn,
  input  logic [PORT_W-$clog2(WORD_W)-1:0] bmWrAddr,
  input  logic [WORD_W-1:0]                bmWrData,
  output logic                             reqReady,
  output logic                             grantValid,
  output logic                             faultValid,
  output logic [1:0]                       faultKind,
  output logic [PORT_W-1:0]                ioAddr,
  output logic [1:0]                       ioSize
);
  gateStrobeT strobe;
  gateStatusT status;

  io_gate_ctl ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .status(status), .strobe(strobe), .reqReady(reqReady)
  );

  io_gate_dp #(.PORT_W(PORT_W), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .protEn(protEn), .v86Mode(v86Mode), .cpl(cpl), .iopl(iopl),
    .portAddr(portAddr), .accSize(accSize), .lockPrefix(lockPrefix),
    .bmWrEn(bmWrEn), .bmWrAddr(bmWrAddr), .bmWrData(bmWrData),
    .grantValid(grantValid), .faultValid(faultValid), .faultKind(faultKind),
    .ioAddr(ioAddr), .ioSize(ioSize)
  );

  // R1: lock prefix yields an invalid-opcode fault next cycle
  a_r1_lock_ud: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lockPrefix) |=> (faultValid && faultKind == 2'd2));

  // R3: privileged or unprotected requests are granted next cycle
  a_r3_fast_grant: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lockPrefix && accSize != 2'd3 &&
     !(protEn && ((cpl > iopl) || v86Mode)))
    |=> (grantValid && ioAddr == $past(portAddr)));

  // R6: a checked request gives no answer in the first cycle
  a_r6_no_early_answer: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lockPrefix && accSize != 2'd3 &&
     protEn && ((cpl > iopl) || v86Mode))
    |=> (!grantValid && !faultValid && !reqReady));

endmodule

// File: tb/io_port_gate_tb_top.sv
module io_port_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W = 10;
  localparam int WORD_W = 8;
  localparam int IDX_W  = PORT_W - $clog2(WORD_W);
  localparam int NVEC   = 20;

  // {protEn, v86, cpl, iopl, lock, size, port, expKind(0 grant), expLatency}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0,1'b0,2'd3,2'd0,1'b0,2'd0,10'd16,  2'd0,2'd1}, // R3 real mode
    {1'b1,1'b0,2'd0,2'd0,1'b0,2'd0,10'd16,  2'd0,2'd1}, // R3 privileged
    {1'b1,1'b0,2'd3,2'd0,1'b0,2'd0,10'd16,  2'd1,2'd2}, // R4 blocked bit
    {1'b1,1'b0,2'd3,2'd0,1'b0,2'd2,10'd17,  2'd0,2'd2}, // R5 17..20 clear
    {1'b1,1'b0,2'd3,2'd0,1'b0,2'd2,10'd20,  2'd1,2'd2}, // R5 20..23 hits 23
    {1'b1,1'b1,2'd0,2'd3,1'b0,2'd0,10'd16,  2'd1,2'd2}, // R4 v86 checks
    {1'b1,1'b1,2'd0,2'd3,1'b0,2'd2,10'd38,  2'd1,2'd3}, // R5 span hits 40
    {1'b1,1'b1,2'd0,2'd3,1'b0,2'd2,10'd36,  2'd0,2'd2}, // R6 one word
    {1'b1,1'b0,2'd3,2'd1,1'b0,2'd2,10'd14,  2'd1,2'd3}, // R5 span hits 16
    {1'b1,1'b0,2'd3,2'd1,1'b0,2'd1,10'd13,  2'd0,2'd2}, // R5 2 bytes clear
    {1'b1,1'b0,2'd3,2'd1,1'b0,2'd1,10'd15,  2'd1,2'd3}, // R5 2 bytes span hit
    {1'b1,1'b0,2'd3,2'd1,1'b0,2'd2,10'd6,   2'd0,2'd3}, // R6 span clear
    {1'b0,1'b0,2'd0,2'd0,1'b1,2'd0,10'd5,   2'd2,2'd1}, // R1 lock real mode
    {1'b1,1'b0,2'd3,2'd0,1'b1,2'd0,10'd16,  2'd2,2'd1}, // R1 lock checked
    {1'b1,1'b0,2'd3,2'd0,1'b0,2'd3,10'd8,   2'd2,2'd1}, // R2 illegal size
    {1'b1,1'b0,2'd3,2'd0,1'b0,2'd2,10'd1022,2'd1,2'd2}, // R7 past top
    {1'b1,1'b0,2'd3,2'd0,1'b0,2'd0,10'd1023,2'd0,2'd2}, // R7 top byte ok
    {1'b0,1'b1,2'd3,2'd0,1'b0,2'd0,10'd16,  2'd0,2'd1}, // R3 v86 without PE
    {1'b1,1'b0,2'd2,2'd2,1'b0,2'd0,10'd16,  2'd0,2'd1}, // R3 equal levels
    {1'b1,1'b0,2'd3,2'd2,1'b0,2'd0,10'd16,  2'd1,2'd2}  // R4 cpl above iopl
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, protEn = 1'b0, v86Mode = 1'b0, lockPrefix = 1'b0;
  logic [1:0] cpl = '0, iopl = '0, accSize = '0;
  logic [PORT_W-1:0] portAddr = '0;
  logic bmWrEn = 1'b0;
  logic [IDX_W-1:0] bmWrAddr = '0;
  logic [WORD_W-1:0] bmWrData = '0;
  logic reqReady, grantValid, faultValid;
  logic [1:0] faultKind, ioSize;
  logic [PORT_W-1:0] ioAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_gate #(.PORT_W(PORT_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .protEn(protEn),
    .v86Mode(v86Mode), .cpl(cpl), .iopl(iopl), .portAddr(portAddr),
    .accSize(accSize), .lockPrefix(lockPrefix), .bmWrEn(bmWrEn),
    .bmWrAddr(bmWrAddr), .bmWrData(bmWrData), .reqReady(reqReady),
    .grantValid(grantValid), .faultValid(faultValid), .faultKind(faultKind),
    .ioAddr(ioAddr), .ioSize(ioSize)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wrWord(input int idx, input int data);
    @(negedge clk);
    bmWrEn = 1'b1; bmWrAddr = IDX_W'(idx); bmWrData = WORD_W'(data);
    @(negedge clk);
    bmWrEn = 1'b0;
  endtask

  task automatic runReq(input string req, input logic pe, input logic v86,
                        input logic [1:0] c, input logic [1:0] io,
                        input logic lk, input logic [1:0] sz,
                        input logic [PORT_W-1:0] port,
                        input int expKind, input int expLat);
    int gotLat = 0;
    int gotKind = 0;
    @(negedge clk);
    check(reqReady == 1'b1, req, "ready before request", int'(reqReady), 1);
    protEn = pe; v86Mode = v86; cpl = c; iopl = io; lockPrefix = lk;
    accSize = sz; portAddr = port; reqValid = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (grantValid && faultValid)
        check(1'b0, "R8", "both pulses", 1, 0);
      if ((grantValid || faultValid) && gotLat == 0) begin
        gotLat = k;
        gotKind = faultValid ? int'(faultKind) : 0;
        if (grantValid) begin
          check(ioAddr == port, req, "ioAddr", int'(ioAddr), int'(port));
          check(ioSize == sz, req, "ioSize", int'(ioSize), int'(sz));
        end
      end else if (gotLat != 0) begin
        // R8: single pulse per request
        check(!grantValid && !faultValid, "R8", "pulse length", 1, 0);
        break;
      end else begin
        check(reqReady == 1'b0, "R6", "ready while pending", int'(reqReady), 0);
      end
    end
    check(gotLat == expLat, req, "latency", gotLat, expLat);
    check(gotKind == expKind, req, "result kind", gotKind, expKind);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state during reset
    check(!grantValid && !faultValid, "R10", "pulses in reset", int'(grantValid), 0);
    check(reqReady == 1'b1, "R10", "ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(!grantValid && !faultValid, "R10", "pulses after reset", int'(faultValid), 0);
    check(reqReady == 1'b1, "R10", "ready after reset", int'(reqReady), 1);

    for (int w = 0; w < (1 << IDX_W); w++) wrWord(w, 0);
    wrWord(2, 8'h81); // ports 16 and 23 blocked
    wrWord(5, 8'h01); // port 40 blocked

    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      v = VEC[i];
      runReq($sformatf("vec%0d", i), v[22], v[21], v[20:19], v[18:17], v[16],
             v[15:14], v[13:4], int'(v[3:2]), int'(v[1:0]));
    end

    // R9: clearing a word releases its ports
    wrWord(2, 0);
    runReq("R9", 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 2'd0, 10'd16, 0, 2);
    // R9: setting a bit blocks a port granted before
    runReq("R9", 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 2'd0, 10'd100, 0, 2);
    wrWord(12, 8'h10);
    runReq("R9", 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 2'd0, 10'd100, 1, 2);
    // R2 and R1 together: still one invalid-opcode fault
    runReq("R2", 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 2'd3, 10'd3, 2, 1);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule